// File: doc/BRIEF.md
# MDIO Management Bus Master

This block drives Clause-22 management frames from a host towards an Ethernet PHY. It uses one shared bidirectional data line and a management clock derived from the system clock. A host hands over one transaction at a time on a valid/ready request port. Each request carries a 2-bit operation code, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then serialises a 64-bit frame: a run of 32 ones, the start code, the operation, both addresses, the turnaround and the data.

The data line is split into an output value, an output enable and an input value, so that a pad ring or bench can resolve it. On a read, the master releases the line when the turnaround begins. It then samples the PHY's answer on the rising management clock edges, most significant bit first. The 16 collected bits are shown on the response port with a one-cycle valid. The management clock runs only while a frame is in flight and rests low in between.

Top module: `mdio_master`

## Requirements
- R1: While the reset input is low, and for the first two clock edges after it rises, req_ready, mdc, mdio_oe and rsp_valid are all 0. After those two edges, req_ready is 1.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. From the next cycle until the frame ends, req_ready stays 0. The request fields are captured at acceptance. Any change of req_valid, req_op, req_phy, req_reg or req_wdata during a frame has no effect on that frame.
- R3: A frame lasts 64 bit periods. It sends, MSB first: 32 ones, the start code 01, req_op, req_phy, req_reg, a 2-bit turnaround, then 16 data bits. Operation code 10 is a read and 01 is a write.
- R4: With DIV = CLK_HZ / MDC_HZ, each bit period lasts DIV clock cycles. Bit period 0 starts in the cycle after acceptance. Within each period, mdc is 0 for the first DIV/2 cycles and 1 for the remaining DIV/2 cycles. Between frames mdc is 0.
- R5: While driven, mdio_o changes only at the start of a bit period, which is where mdc falls or the frame begins.
- R6: On a write, mdio_oe is 1 for all 64 bit periods. The turnaround is driven as 10 and the data field carries req_wdata.
- R7: On a read, mdio_oe is 1 for bit periods 0 to 45. It is 0 from the start of the turnaround (period 46) to the end of the frame.
- R8: On a read, mdio_i is sampled at the clock edge where mdc rises, in each of bit periods 48 to 63. The samples are shifted in so that the one from period 48 lands in bit 15 of the result.
- R9: After a read frame, rsp_valid is 1 for exactly one cycle: the cycle after the last bit period ends. In that cycle rsp_rdata holds the 16 sampled bits. Write frames raise no response.
- R10: req_ready returns to 1 in the same cycle that follows the last bit period. A request presented then is accepted at the next edge, so back-to-back frames are separated by exactly one idle cycle.
- R11: Operation codes 00 and 11 are sent as given and handled like a write. The line is driven for the whole frame with turnaround 10 and req_wdata as data, and no response is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle and able to take a request |
| req_op | input | 2 | Operation code (10 read, 01 write) |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for write frames |
| rsp_valid | output | 1 | One-cycle strobe after a read frame |
| rsp_rdata | output | 16 | Data collected by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value seen on the data line |

## Verification
The bench builds the master with CLK_HZ = 50,000,000 and MDC_HZ = 2,500,000, which gives a divide ratio of 20. A full frame then fits in 1280 cycles, so several writes, reads with all-zero, all-one and alternating answers, an illegal operation code and back-to-back transfers all fit in one short run. Because the ratio is even but different from the default 40, an error that hard-codes the default half period shows up as an mdc or sampling mismatch. A behavioural model plays the PHY, drives mdio_i for each data bit period, and predicts every output cycle by cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned PREAMBLE_BITS = 32;
  localparam int unsigned OP_W          = 2;
  localparam int unsigned ADDR_W        = 5;
  localparam int unsigned DATA_W        = 16;
  localparam int unsigned FRAME_BITS    = PREAMBLE_BITS + 2 + OP_W + 2 * ADDR_W + 2 + DATA_W;
  // bit period where the turnaround begins, and where data begins
  localparam int unsigned TA_POS        = PREAMBLE_BITS + 2 + OP_W + 2 * ADDR_W;
  localparam int unsigned DATA_POS      = TA_POS + 2;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] TA_DRIVEN  = 2'b10;
  localparam logic [1:0] TA_PAD     = 2'b11;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [OP_W-1:0]   op,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] reg_a,
    input logic [DATA_W-1:0] wdata
  );
    logic rd;
    rd = (op == OP_READ);
    return {{PREAMBLE_BITS{1'b1}}, START_CODE, op, phy, reg_a,
            rd ? TA_PAD : TA_DRIVEN, rd ? {DATA_W{1'b0}} : wdata};
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] ph_q, ph_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    if (!run)                       ph_d = '0;
    else if (ph_q == CW'(DIV - 1))  ph_d = '0;
    else                            ph_d = ph_q + CW'(1);
    mdc_d = run && (ph_d >= CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mdc_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = run && (ph_q == CW'(HALF - 1));
  assign fall_stb = run && (ph_q == CW'(DIV - 1));

  // R4: a rise strobe is always followed by mdc high
  p_rise_then_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);

endmodule

// File: rtl/mdio_field_timer.sv
module mdio_field_timer #(
  parameter int unsigned BITS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    step,
  output logic [$clog2(BITS)-1:0] bit_idx,
  output logic                    last_bit
);
  localparam int unsigned W = $clog2(BITS);

  logic [W-1:0] idx_q, idx_d;

  always_comb begin
    if (!run)       idx_d = '0;
    else if (step)  idx_d = (idx_q == W'(BITS - 1)) ? '0 : idx_q + W'(1);
    else            idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign bit_idx  = idx_q;
  assign last_bit = (idx_q == W'(BITS - 1));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned MDC_HZ = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int unsigned DIV   = CLK_HZ / MDC_HZ;
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);

  typedef enum logic {S_IDLE, S_FRAME} state_e;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_e                state_q, state_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  rd_q, rd_d;
  logic                  rsp_q, rsp_d;
  logic                  busy, accept, rise_stb, fall_stb, last_bit;
  logic [IDX_W-1:0]      bit_idx;

  assign busy = (state_q == S_FRAME);

  mdio_clkdiv #(.DIV(DIV)) u_clkdiv (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_field_timer #(.BITS(FRAME_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (busy),
    .step     (fall_stb),
    .bit_idx  (bit_idx),
    .last_bit (last_bit)
  );

  assign req_ready = rst_int_n && !busy;
  assign accept    = req_valid && req_ready;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept)              state_d = S_FRAME;
      S_FRAME: if (fall_stb && last_bit) state_d = S_IDLE;
      default:                           state_d = S_IDLE;
    endcase
  end

  // datapath next values
  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    rd_d  = rd_q;
    rsp_d = 1'b0;
    if (accept) begin
      tx_d = build_frame(req_op, req_phy, req_reg, req_wdata);
      rd_d = (req_op == OP_READ);
    end else if (fall_stb) begin
      tx_d  = {tx_q[FRAME_BITS-2:0], 1'b0};
      rsp_d = last_bit && rd_q;
    end
    if (rise_stb && rd_q && (bit_idx >= IDX_W'(DATA_POS)))
      rx_d = {rx_q[DATA_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      rd_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      rd_q    <= rd_d;
      rsp_q   <= rsp_d;
    end
  end

  assign mdio_o    = tx_q[FRAME_BITS-1];
  assign mdio_oe   = busy && !(rd_q && (bit_idx >= IDX_W'(TA_POS)));
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rx_q;

  // R2: acceptance closes the request port
  p_accept_closes_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> !req_ready);

  // R4: the management clock rests low between frames
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (!mdc && !mdio_oe));

  // R5: inside a frame the driven value moves only on a falling mdc
  p_change_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  // R7: the line is released mid-frame only by a read
  p_release_read_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(mdio_oe) && busy) |-> rd_q);

  // R9: the response strobe lasts one cycle
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int CLK_HZ = 50_000_000;
  localparam int MDC_HZ = 2_500_000;
  localparam int DIV    = CLK_HZ / MDC_HZ;
  localparam int HALF   = DIV / 2;
  localparam int NBITS  = 64;
  localparam int FCYC   = NBITS * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // behavioural model state
  int          rcnt = 0;
  bit          mbusy = 0;
  int          t = 0;
  bit          m_rd = 0;
  bit [1:0]    m_op = 0;
  bit [63:0]   mframe = 0;
  bit [15:0]   mpd = 0;
  bit          exp_rsp = 0;
  bit [15:0]   exp_data = 0;
  logic [15:0] phy_data = '0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; mbusy = 0; exp_rsp = 0; t = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      exp_rsp = 0;
      if (mbusy) begin
        if (t == FCYC - 1) begin
          mbusy = 0; exp_rsp = m_rd; exp_data = mpd;
        end else t++;
      end else if (req_valid) begin
        mbusy  = 1; t = 0;
        m_op   = req_op;
        m_rd   = (req_op == 2'b10);
        mframe = {32'hFFFF_FFFF, 2'b01, req_op, req_phy, req_reg,
                  m_rd ? 2'b11 : 2'b10, m_rd ? 16'h0000 : req_wdata};
        mpd    = phy_data;
      end
    end
  end

  // compare on every clock, away from the active edge; also act as the PHY
  always @(negedge clk) begin
    int  b, ph;
    bit  e_ready, e_mdc, e_oe;
    string t_idle, t_oe;
    cycles++;
    b  = t / DIV;
    ph = t % DIV;
    e_ready = (rcnt >= 2) && !mbusy;
    e_mdc   = mbusy && (ph >= HALF);
    e_oe    = mbusy && !(m_rd && b >= 46);
    t_idle  = (rcnt < 2) ? "R1" : "R2 R10";
    t_oe    = !mbusy ? "R1 R4" : (m_rd ? "R7" : (m_op == 2'b01 ? "R6" : "R11"));
    check(t_idle, "req_ready", req_ready, e_ready);
    check((rcnt < 2) ? "R1" : "R4", "mdc", mdc, e_mdc);
    check(t_oe, "mdio_oe", mdio_oe, e_oe);
    if (e_oe) check(m_op == 2'b01 || m_rd ? "R3 R5 R6" : "R11", "mdio_o", mdio_o, mframe[63-b]);
    check((rcnt < 2) ? "R1" : "R9", "rsp_valid", rsp_valid, exp_rsp);
    if (exp_rsp) check("R8 R9", "rsp_rdata", rsp_rdata, exp_data);
    if (mbusy && m_rd && b >= 48) mdio_i = mpd[15 - (b - 48)];
    else                          mdio_i = 1'b1;
  end

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pd, input int junk);
    req_valid = 1'b1; req_op = op; req_phy = phy; req_reg = ra; req_wdata = wd;
    phy_data = pd;
    @(posedge clk);
    @(negedge clk);
    // R2: scrambled fields and a held valid during the frame must be ignored
    req_op = ~op; req_phy = ~phy; req_reg = ~ra; req_wdata = ~wd;
    req_valid = (junk > 0);
    repeat (junk) @(negedge clk);
    req_valid = 1'b0;
    while (mbusy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(2'b01, 5'h01, 5'h1F, 16'hA5C3, 16'h0000, 0);   // R6 write
    run_frame(2'b10, 5'h1E, 5'h02, 16'h1234, 16'h8001, 50);  // R7 R8 read, junk held
    run_frame(2'b10, 5'h00, 5'h00, 16'h0000, 16'hFFFF, 0);   // R8 all ones
    repeat (5) @(negedge clk);
    run_frame(2'b10, 5'h15, 5'h0A, 16'hFFFF, 16'h0000, 0);   // R8 all zeros
    run_frame(2'b10, 5'h0A, 5'h15, 16'h0F0F, 16'h5A96, 0);   // R10 back to back
    run_frame(2'b11, 5'h07, 5'h11, 16'hC33C, 16'h0000, 10);  // R11 odd opcode
    run_frame(2'b00, 5'h19, 5'h04, 16'h0001, 16'h0000, 0);   // R11 odd opcode
    run_frame(2'b01, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 0);   // R3 R6
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule